// File: doc/BRIEF.md
# Retirement-Aware Watchpoint Event Counter

This block keeps a small set of programmable down counters that count watchpoint hits. Each counter is pointed at one of the instruction watchpoint lines or one of the load/store watchpoint lines. It is loaded with a start value and steps down by one on every cycle in which its chosen line fires. When it reaches zero it raises a flag and sends out a one-cycle expiry pulse. A debug controller can use that pulse to stop the machine after the Nth occurrence of an event.

Watchpoint lines fire when an event is seen, and that can happen before the pipeline knows whether the instruction will retire. When an exception, an interrupt or a mispredicted branch flushes younger work, the pipeline reports on a recovery input how many counted events belonged to that flushed work. The counter adds that number back. The net count then reflects only work that really executed. A counter that has expired stays frozen until it is loaded again, so a flush after expiry cannot bring it back to life.

Top module: `wp_event_counter`

## Requirements
- R1: Each counter is independent and `CNT_W` (default 16) bits wide. A write on the configuration port loads the value, the enable, the source kind and the line select into the counter named by the index. The new value shows on `cnt_o` after the next clock edge, and no other counter changes.
- R2: Source kind 0 selects instruction watchpoint line `iwp_evt_i[sel]`. Source kind 1 selects load/store line `lwp_evt_i[sel]`. A select beyond the number of lines of that kind never produces an event.
- R3: An enabled counter with a nonzero value decreases by one at every clock edge where its selected line is high.
- R4: An enabled nonzero counter increases by its recovery amount, the unsigned field `rec_amt_i[c*REC_W +: REC_W]`, at that clock edge.
- R5: A decrement and a recovery in the same cycle combine into value − 1 + amount. A decrement together with an amount of 1 leaves the value unchanged.
- R6: Increases saturate at the all-ones value (0xFFFF by default) and never wrap.
- R7: A counter at zero ignores both events and recovery until it is reloaded. `zero_o[c]` is high exactly while the value is zero.
- R8: A disabled counter ignores events and recovery and keeps its value.
- R9: `expire_o[c]` is high for exactly one cycle, the first cycle in which a counted step has taken a nonzero value to zero. Loading zero never raises it.
- R10: A configuration write to a counter takes priority over any event or recovery for that counter in the same cycle.
- R11: After reset every counter holds zero, is disabled, shows `zero_o` high and `expire_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Counter targeted by the write |
| cfg_en_i | input | 1 | Enable written to the counter |
| cfg_src_i | input | 1 | Source kind: 0 instruction, 1 load/store |
| cfg_sel_i | input | SEL_W | Line select within the source kind |
| cfg_val_i | input | CNT_W | Start value |
| iwp_evt_i | input | NUM_IWP | Instruction watchpoint hits this cycle |
| lwp_evt_i | input | NUM_LWP | Load/store watchpoint hits this cycle |
| rec_amt_i | input | NUM_CNT*REC_W | Per-counter number of flushed counted events |
| cnt_o | output | NUM_CNT*CNT_W | Current counter values |
| zero_o | output | NUM_CNT | Counter holds zero |
| expire_o | output | NUM_CNT | One-cycle expiry pulse |

## Verification
The bench goes after the cycle where a hit and a flush of one event coincide. A design that gave either one priority would drift by one count. It checks the step from 1 to 0 with a flush arriving just after. A design that let recovery revive an expired counter would report a second expiry or a nonzero value. It also checks a load of 0xFFFE followed by a large flush, where a wrapping adder would show a small value. It checks out-of-range load/store selects and writes that collide with hits, where a loose decoder or a wrong priority shows up as a stray decrement. A long random mix is compared against the bench's own model on every cycle.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic {
      SRC_INSTR = 1'b0,
      SRC_LDST  = 1'b1
   } wpc_src_e;

   function automatic int unsigned wpc_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wpc_src_mux.sv
module wpc_src_mux
   import wpc_pkg::*;
#(
   parameter int unsigned NUM_IWP = 4,
   parameter int unsigned NUM_LWP = 2,
   parameter int unsigned SEL_W   = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic               load_src_i,
   input  logic [SEL_W-1:0]   load_sel_i,
   input  logic [NUM_IWP-1:0] iwp_i,
   input  logic [NUM_LWP-1:0] lwp_i,
   output logic               evt_o
);
   wpc_src_e         src_q;
   logic [SEL_W-1:0] sel_q;
   logic             hit_i_line;
   logic             hit_l_line;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q <= SRC_INSTR;
         sel_q <= '0;
      end else if (load_i) begin
         src_q <= wpc_src_e'(load_src_i);
         sel_q <= load_sel_i;
      end
   end

   always_comb begin
      hit_i_line = 1'b0;
      for (int i = 0; i < int'(NUM_IWP); i++)
         if (sel_q == SEL_W'(i)) hit_i_line = iwp_i[i];
   end

   always_comb begin
      hit_l_line = 1'b0;
      for (int i = 0; i < int'(NUM_LWP); i++)
         if (sel_q == SEL_W'(i)) hit_l_line = lwp_i[i];
   end

   assign evt_o = (src_q == SRC_LDST) ? hit_l_line : hit_i_line;

   // A load/store select past the last line can never produce a hit.
   AST_LDST_SEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_q == SRC_LDST && int'(sel_q) >= int'(NUM_LWP)) |-> !evt_o); // R2
endmodule

// File: rtl/wpc_down_cnt.sv
module wpc_down_cnt #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned REC_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             load_en_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             evt_i,
   input  logic [REC_W-1:0] rec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o,
   output logic             expire_o
);
   localparam int unsigned SUM_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic             exp_q;
   logic             live;
   logic             dec;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] cnt_step;

   assign live = en_q && (cnt_q != '0);
   assign dec  = live && evt_i;

   always_comb begin
      sum = {1'b0, cnt_q} + SUM_W'(rec_i) - SUM_W'(dec);
      cnt_step = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
         exp_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         en_q  <= load_en_i;
         exp_q <= 1'b0;
      end else if (live) begin
         cnt_q <= cnt_step;
         exp_q <= (cnt_step == '0);
      end else begin
         exp_q <= 1'b0;
      end
   end

   assign cnt_o    = cnt_q;
   assign zero_o   = (cnt_q == '0);
   assign expire_o = exp_q;

   AST_ZERO_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zero_o && !load_i) |=> zero_o); // R7
   AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q && !load_i) |=> $stable(cnt_o)); // R8
   AST_HIT_FLUSH_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && live && evt_i && rec_i == REC_W'(1)) |=> $stable(cnt_o)); // R5
   AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && live && cnt_o == CNT_MAX && !evt_i) |=> cnt_o == CNT_MAX); // R6
   AST_EXPIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |=> !expire_o); // R9
   AST_EXPIRE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_o |-> zero_o); // R9
   AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cnt_o == $past(load_val_i) && !expire_o)); // R10
endmodule

// File: rtl/wp_event_counter.sv
module wp_event_counter
   import wpc_pkg::*;
#(
   parameter int unsigned NUM_CNT = 2,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_IWP = 4,
   parameter int unsigned NUM_LWP = 2,
   parameter int unsigned REC_W   = 3,
   localparam int unsigned IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
   localparam int unsigned SEL_MX = wpc_max(NUM_IWP, NUM_LWP),
   localparam int unsigned SEL_W  = (SEL_MX > 1) ? $clog2(SEL_MX) : 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     cfg_we_i,
   input  logic [IDX_W-1:0]         cfg_idx_i,
   input  logic                     cfg_en_i,
   input  logic                     cfg_src_i,
   input  logic [SEL_W-1:0]         cfg_sel_i,
   input  logic [CNT_W-1:0]         cfg_val_i,
   input  logic [NUM_IWP-1:0]       iwp_evt_i,
   input  logic [NUM_LWP-1:0]       lwp_evt_i,
   input  logic [NUM_CNT*REC_W-1:0] rec_amt_i,
   output logic [NUM_CNT*CNT_W-1:0] cnt_o,
   output logic [NUM_CNT-1:0]       zero_o,
   output logic [NUM_CNT-1:0]       expire_o
);
   if (NUM_CNT < 1)          begin : g_bad_cnt  $error("NUM_CNT must be at least 1");   end
   if (CNT_W < 2)            begin : g_bad_w    $error("CNT_W must be at least 2");     end
   if (REC_W < 1 || REC_W >= CNT_W) begin : g_bad_rec $error("REC_W must be 1..CNT_W-1"); end
   if (NUM_IWP < 1 || NUM_LWP < 1)  begin : g_bad_src $error("each source kind needs a line"); end

   logic [NUM_CNT-1:0] load_vec;

   always_comb begin
      load_vec = '0;
      for (int c = 0; c < int'(NUM_CNT); c++)
         load_vec[c] = cfg_we_i && (cfg_idx_i == IDX_W'(c));
   end

   for (genvar c = 0; c < NUM_CNT; c++) begin : g_slot
      logic evt_sel;

      wpc_src_mux #(
         .NUM_IWP (NUM_IWP),
         .NUM_LWP (NUM_LWP),
         .SEL_W   (SEL_W)
      ) mux_i (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .load_i     (load_vec[c]),
         .load_src_i (cfg_src_i),
         .load_sel_i (cfg_sel_i),
         .iwp_i      (iwp_evt_i),
         .lwp_i      (lwp_evt_i),
         .evt_o      (evt_sel)
      );

      wpc_down_cnt #(
         .CNT_W (CNT_W),
         .REC_W (REC_W)
      ) cnt_i (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .load_i     (load_vec[c]),
         .load_en_i  (cfg_en_i),
         .load_val_i (cfg_val_i),
         .evt_i      (evt_sel),
         .rec_i      (rec_amt_i[c*REC_W +: REC_W]),
         .cnt_o      (cnt_o[c*CNT_W +: CNT_W]),
         .zero_o     (zero_o[c]),
         .expire_o   (expire_o[c])
      );
   end

   AST_UNTOUCHED_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_idx_i == '0 && zero_o[NUM_CNT-1] && NUM_CNT > 1) |=> zero_o[NUM_CNT-1]); // R1
   AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (expire_o == '0)); // R11
endmodule

// File: tb/wp_event_counter_tb.sv
module wp_event_counter_tb_top;
   localparam int NC = 2, W = 16, NI = 4, NL = 2, RW = 3;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_src = 1'b0;
   logic [0:0] cfg_idx = '0;
   logic [1:0] cfg_sel = '0;
   logic [W-1:0] cfg_val = '0;
   logic [NI-1:0] iwp = '0;
   logic [NL-1:0] lwp = '0;
   logic [NC*RW-1:0] rec = '0;
   logic [NC*W-1:0] cnt;
   logic [NC-1:0] zero, expire;

   int total = 0, bad = 0;
   string cur_req = "R11";
   int m_cnt [NC];
   bit m_en [NC], m_src [NC], m_exp [NC];
   int m_sel [NC];

   always #4 clk = ~clk;

   wp_event_counter dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
      .cfg_en_i(cfg_en), .cfg_src_i(cfg_src), .cfg_sel_i(cfg_sel), .cfg_val_i(cfg_val),
      .iwp_evt_i(iwp), .lwp_evt_i(lwp), .rec_amt_i(rec),
      .cnt_o(cnt), .zero_o(zero), .expire_o(expire));

   // Behavioural reference
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NC; c++) begin
            m_cnt[c] = 0; m_en[c] = 0; m_src[c] = 0; m_sel[c] = 0; m_exp[c] = 0;
         end
      end else begin
         for (int c = 0; c < NC; c++) begin
            if (cfg_we && int'(cfg_idx) == c) begin
               m_cnt[c] = cfg_val; m_en[c] = cfg_en; m_src[c] = cfg_src;
               m_sel[c] = cfg_sel; m_exp[c] = 0;
            end else if (m_en[c] && m_cnt[c] != 0) begin
               int hit, n;
               if (m_src[c]) hit = (m_sel[c] < NL) ? int'(lwp[m_sel[c]]) : 0;
               else          hit = (m_sel[c] < NI) ? int'(iwp[m_sel[c]]) : 0;
               n = m_cnt[c] - hit + int'(rec[c*RW +: RW]);
               if (n > MAXV) n = MAXV;
               m_exp[c] = (n == 0);
               m_cnt[c] = n;
            end else begin
               m_exp[c] = 0;
            end
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      for (int c = 0; c < NC; c++) begin
         chk($sformatf("cnt%0d", c), int'(cnt[c*W +: W]), m_cnt[c]);
         chk($sformatf("zero%0d", c), int'(zero[c]), int'(m_cnt[c] == 0));
         chk($sformatf("expire%0d", c), int'(expire[c]), int'(m_exp[c]));
      end
   endtask

   // Compare at the falling edge, then apply the next inputs.
   task automatic step(bit we, int idx, bit en, bit src, int sel, int val,
                       int iv, int lv, int r0, int r1);
      @(negedge clk);
      compare();
      cfg_we = we; cfg_idx = idx[0:0]; cfg_en = en; cfg_src = src;
      cfg_sel = sel[1:0]; cfg_val = val[W-1:0];
      iwp = iv[NI-1:0]; lwp = lv[NL-1:0];
      rec = {r1[RW-1:0], r0[RW-1:0]};
   endtask

   task automatic idle(int r0, int r1, int iv, int lv);
      step(0, 0, 0, 0, 0, 0, iv, lv, r0, r1);
   endtask

   initial begin
      #2000000;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare();                        // R11 reset state
      rst_n = 1'b1;
      idle(0, 0, 0, 0);
      cur_req = "R1";
      step(1, 0, 1, 0, 2, 5, 0, 0, 0, 0);   // c0: instr line 2, value 5
      step(1, 1, 1, 1, 1, 3, 0, 0, 0, 0);   // c1: ld/st line 1, value 3
      idle(0, 0, 0, 0);
      cur_req = "R3";
      idle(0, 0, 4'b0100, 0);
      idle(0, 0, 4'b0100, 0);
      cur_req = "R2";
      idle(0, 0, 4'b1011, 2'b01);           // unselected lines only
      idle(0, 0, 0, 2'b10);
      cur_req = "R4";
      idle(2, 0, 0, 0);
      cur_req = "R5";
      idle(1, 1, 4'b0100, 2'b10);
      idle(1, 0, 4'b0100, 0);
      cur_req = "R9";
      idle(0, 0, 0, 2'b10);
      idle(0, 0, 0, 2'b10);                 // c1 reaches zero here
      cur_req = "R7";
      idle(0, 5, 0, 2'b10);
      idle(0, 7, 0, 2'b10);
      idle(0, 0, 0, 0);
      cur_req = "R6";
      step(1, 1, 1, 0, 0, MAXV - 1, 0, 0, 0, 0);
      idle(0, 7, 0, 0);
      idle(0, 3, 0, 0);
      cur_req = "R8";
      step(1, 0, 0, 0, 2, 9, 0, 0, 0, 0);
      idle(3, 0, 4'b0100, 0);
      idle(0, 0, 4'b0100, 0);
      cur_req = "R2";
      step(1, 0, 1, 1, 3, 9, 0, 0, 0, 0);  // ld/st select out of range
      idle(0, 0, 4'b1111, 2'b11);
      idle(0, 0, 4'b1111, 2'b11);
      cur_req = "R10";
      step(1, 0, 1, 0, 1, 4, 4'b0010, 0, 5, 0);
      idle(0, 0, 4'b0010, 0);
      cur_req = "R9";
      step(1, 0, 1, 0, 1, 0, 4'b0010, 0, 0, 0);  // load zero: no pulse
      idle(0, 0, 0, 0);
      step(1, 0, 1, 0, 1, 1, 0, 0, 0, 0);
      idle(1, 0, 4'b0010, 0);               // 1 with hit+flush stays 1
      idle(0, 0, 4'b0010, 0);
      idle(0, 0, 0, 0);
      cur_req = "R3";
      for (int k = 0; k < 400; k++) begin
         int r0, r1;
         r0 = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 7)) : 0;
         r1 = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 7)) : 0;
         if ($urandom_range(0, 15) == 0)
            step(1, int'($urandom_range(0, 1)), bit'($urandom_range(0, 3) != 0),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 12)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 3)), r0, r1);
         else
            idle(r0, r1, int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
      end
      idle(0, 0, 0, 0);
      @(negedge clk);
      compare();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule